// File: doc/BRIEF.md
# Clock Root Configuration Controller

This block is the programming side of a clock root. Software writes a staged set of settings through a small synchronous word bus: which source to use, a half-integer pre-divider, a counter mode, and the three values that steer a fractional M/N divider. None of these settings reach the divider until software requests a commit. The commit copies every staged value into the active set in one step, after a fixed latency. During that time the commit bit reads back as 1, so software can poll for completion.

The N and D values are stored in an inverted form. N is held as the inverse of (N − M), and D is held as the inverse of twice the duty value. The block decodes both for the downstream divider and clamps the duty value into its legal window. The block also shows whether the root is running, and it has a force bit that keeps the root on while it is being reprogrammed. The divider datapath itself is not part of this block. It sees only the decoded active settings on the output ports.

Top module: `clk_root_cfg`

## Requirements
- R1: After reset every staged and active field is zero, `root_on` is 0, and the command word (address 0x00) reads 0x8000_0000: only the root-off bit 31 is set.
- R2: The configuration word (address 0x04) holds the pre-divider in bits 4:0, the source select in bits 10:8, the mode in bits 12..13, and the hardware-control flag in bit 20. Unused bits read 0. M (0x08), N (0x0C) and D (0x10) hold 8 bits each in bits 7:0.
- R3: Writing the command word with bit 0 set starts a commit. Bit 0 reads 1 and the active outputs keep their old values for exactly COMMIT_LAT (default 4) cycles. On the next cycle the active set equals the staged set and bit 0 reads 0.
- R4: A second commit request written while a commit is pending has no effect. The pending commit still completes COMMIT_LAT cycles after the first request.
- R5: The pending-change flags in command bits 4 (config), 5 (N), 6 (M) and 7 (D) set when the matching register is written. They all clear when a commit completes.
- R6: `act_n` equals the bitwise inverse of the active N register plus the active M, modulo 256.
- R7: `act_d2` is the bitwise inverse of the active D register. When this value exceeds N − M (the inverse of the N register) it is replaced by N − M. Otherwise, when it is below M, it is replaced by M.
- R8: `mnd_en` is 1 exactly when the active mode equals 2 (dual edge) and the active N register is not 0xFF. An N register of 0xFF means N equals M.
- R9: `act_hdiv` carries the active pre-divider field (output = 2·input/(h+1)). `act_bypass` is 1 exactly when that field is 0.
- R10: Command bit 1 is the force-on bit and reads back as written. One cycle after `root_req` or force-on goes high, `root_on` rises and command bit 31 reads 0. One cycle after both are low, `root_on` is 0 again.
- R11: A commit made while the root is off and force-on is clear still updates the active set, and command bit 31 stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| root_req | input | 1 | Enable vote from the downstream clock branches |
| act_src | output | 3 | Active source select |
| act_hdiv | output | 5 | Active half-integer pre-divider |
| act_bypass | output | 1 | Pre-divider is bypassed |
| act_hwctl | output | 1 | Active hardware-control flag |
| mnd_en | output | 1 | Dual-edge M/N counter is in use |
| act_m | output | 8 | Decoded M |
| act_n | output | 8 | Decoded N |
| act_d2 | output | 8 | Decoded and clamped 2·D |
| root_on | output | 1 | Root clock is running |

## Verification
The bench checks how long the commit takes. A sequencer that finishes one cycle early or late, or that restarts when a second request arrives, shows a wrong value in the bit-0 poll or leaves stale active outputs at the sampled cycle. The decode vectors cover several cases: duty values below M, duty values above N − M, the degenerate case N = M (where the window collapses and `mnd_en` must drop), and a mode other than dual edge. A decoder that skips the inversion, applies the clamps in the wrong order, or gates `mnd_en` on the mode alone gives values that differ from the expected ones. The bench also checks that a commit with the root off still updates the active set, and that the force bit shows up in `root_on` and in status bit 31 one cycle after it is written. A design that gates the commit on the root state would leave the old outputs in place.

// File: rtl/clk_root_pkg.sv
package clk_root_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int DIV_W  = 5;
    localparam int SRC_W  = 3;
    localparam int MODE_W = 2;
    localparam int MND_W  = 8;

    localparam logic [ADDR_W-1:0] ADR_CMD = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_CFG = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_M   = 5'h08;
    localparam logic [ADDR_W-1:0] ADR_N   = 5'h0C;
    localparam logic [ADDR_W-1:0] ADR_D   = 5'h10;

    localparam int CMD_UPD_BIT   = 0;
    localparam int CMD_FORCE_BIT = 1;
    localparam int CMD_DIRTY_LSB = 4;
    localparam int CMD_OFF_BIT   = 31;

    localparam int CFG_SRC_LSB  = 8;
    localparam int CFG_MODE_LSB = 12;
    localparam int CFG_HW_BIT   = 20;

    localparam logic [MODE_W-1:0] MODE_DUAL = 2'b10;

    // dirty flag indices, matching command bits 4..7
    localparam int DRT_CFG = 0;
    localparam int DRT_N   = 1;
    localparam int DRT_M   = 2;
    localparam int DRT_D   = 3;

    typedef struct packed {
        logic              hwctl;
        logic [MODE_W-1:0] mode;
        logic [SRC_W-1:0]  src;
        logic [DIV_W-1:0]  hdiv;
    } cfg_t;

    typedef struct packed {
        logic [MND_W-1:0] m;
        logic [MND_W-1:0] nreg;
        logic [MND_W-1:0] dreg;
    } mnd_t;

    typedef struct packed {
        cfg_t cfg;
        mnd_t mnd;
    } stage_t;

    function automatic logic [DATA_W-1:0] cfg_to_word(cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DIV_W-1:0] = c.hdiv;
        w[CFG_SRC_LSB +: SRC_W] = c.src;
        w[CFG_MODE_LSB +: MODE_W] = c.mode;
        w[CFG_HW_BIT] = c.hwctl;
        return w;
    endfunction

    function automatic cfg_t word_to_cfg(logic [DATA_W-1:0] w);
        cfg_t c;
        c.hdiv  = w[DIV_W-1:0];
        c.src   = w[CFG_SRC_LSB +: SRC_W];
        c.mode  = w[CFG_MODE_LSB +: MODE_W];
        c.hwctl = w[CFG_HW_BIT];
        return c;
    endfunction

    function automatic logic [MND_W-1:0] dec_n(logic [MND_W-1:0] m,
                                               logic [MND_W-1:0] nreg);
        return (~nreg) + m;
    endfunction

    function automatic logic [MND_W-1:0] dec_d2(logic [MND_W-1:0] m,
                                                logic [MND_W-1:0] nreg,
                                                logic [MND_W-1:0] dreg);
        logic [MND_W-1:0] raw;
        logic [MND_W-1:0] hi;
        raw = ~dreg;
        hi  = ~nreg;
        if (raw > hi)
            return hi;
        else if (raw < m)
            return m;
        else
            return raw;
    endfunction

endpackage

// File: rtl/clk_root_stage.sv
module clk_root_stage
    import clk_root_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              done_i,
    output stage_t            stg_o,
    output logic [3:0]        dirty_o,
    output logic              force_o,
    output logic              upd_req_o
);

    stage_t     stg_q;
    logic [3:0] dirty_q;
    logic       force_q;

    assign upd_req_o = wr_i && (addr_i == ADR_CMD) && wdata_i[CMD_UPD_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q   <= '0;
            dirty_q <= '0;
            force_q <= 1'b0;
        end else begin
            if (done_i)
                dirty_q <= '0;
            if (wr_i) begin
                case (addr_i)
                    ADR_CMD: force_q <= wdata_i[CMD_FORCE_BIT];
                    ADR_CFG: begin
                        stg_q.cfg        <= word_to_cfg(wdata_i);
                        dirty_q[DRT_CFG] <= 1'b1;
                    end
                    ADR_M: begin
                        stg_q.mnd.m    <= wdata_i[MND_W-1:0];
                        dirty_q[DRT_M] <= 1'b1;
                    end
                    ADR_N: begin
                        stg_q.mnd.nreg <= wdata_i[MND_W-1:0];
                        dirty_q[DRT_N] <= 1'b1;
                    end
                    ADR_D: begin
                        stg_q.mnd.dreg <= wdata_i[MND_W-1:0];
                        dirty_q[DRT_D] <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign stg_o   = stg_q;
    assign dirty_o = dirty_q;
    assign force_o = force_q;

    // R5
    dirty_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == ADR_CFG) |=> dirty_q[DRT_CFG]);

endmodule

// File: rtl/clk_root_commit.sv
module clk_root_commit #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic upd_req_i,
    output logic pend_o,
    output logic load_o
);

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_q;
    logic          pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (pend_q) begin
            if (cnt_q == CW'(1))
                pend_q <= 1'b0;
            else
                cnt_q <= cnt_q - CW'(1);
        end else if (upd_req_i) begin
            pend_q <= 1'b1;
            cnt_q  <= CW'(LAT);
        end
    end

    assign pend_o = pend_q;
    assign load_o = pend_q && (cnt_q == CW'(1));

    // R3
    commit_start_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_req_i && !pend_q) |=> pend_q);

endmodule

// File: rtl/clk_root_active.sv
module clk_root_active
    import clk_root_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  stage_t           stg_i,
    output logic [SRC_W-1:0] src_o,
    output logic [DIV_W-1:0] hdiv_o,
    output logic             bypass_o,
    output logic             hwctl_o,
    output logic             mnd_en_o,
    output logic [MND_W-1:0] m_o,
    output logic [MND_W-1:0] n_o,
    output logic [MND_W-1:0] d2_o
);

    stage_t act_q;

    always_ff @(posedge clk) begin
        if (rst)
            act_q <= '0;
        else if (load_i)
            act_q <= stg_i;
    end

    assign src_o    = act_q.cfg.src;
    assign hdiv_o   = act_q.cfg.hdiv;
    assign bypass_o = (act_q.cfg.hdiv == '0);
    assign hwctl_o  = act_q.cfg.hwctl;
    assign mnd_en_o = (act_q.cfg.mode == MODE_DUAL) && (act_q.mnd.nreg != '1);
    assign m_o      = act_q.mnd.m;
    assign n_o      = dec_n(act_q.mnd.m, act_q.mnd.nreg);
    assign d2_o     = dec_d2(act_q.mnd.m, act_q.mnd.nreg, act_q.mnd.dreg);

    // R3
    act_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (act_q == $past(stg_i)));

    // R3
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(act_q));

    // R7
    d2_window_chk: assert property (@(posedge clk) disable iff (rst)
        (m_o <= ~act_q.mnd.nreg) |-> (d2_o >= m_o && d2_o <= ~act_q.mnd.nreg));

endmodule

// File: rtl/clk_root_cfg.sv
module clk_root_cfg
    import clk_root_pkg::*;
#(
    parameter int COMMIT_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              root_req,
    output logic [2:0]        act_src,
    output logic [4:0]        act_hdiv,
    output logic              act_bypass,
    output logic              act_hwctl,
    output logic              mnd_en,
    output logic [7:0]        act_m,
    output logic [7:0]        act_n,
    output logic [7:0]        act_d2,
    output logic              root_on
);

    localparam int LCW = $clog2(COMMIT_LAT + 2);

    stage_t     stg;
    logic [3:0] dirty;
    logic       force_on;
    logic       upd_req;
    logic       pend;
    logic       load;
    logic       root_on_q;

    clk_root_stage i_stage (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .done_i    (load),
        .stg_o     (stg),
        .dirty_o   (dirty),
        .force_o   (force_on),
        .upd_req_o (upd_req)
    );

    clk_root_commit #(.LAT(COMMIT_LAT)) i_commit (
        .clk       (clk),
        .rst       (rst),
        .upd_req_i (upd_req),
        .pend_o    (pend),
        .load_o    (load)
    );

    clk_root_active i_active (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .stg_i    (stg),
        .src_o    (act_src),
        .hdiv_o   (act_hdiv),
        .bypass_o (act_bypass),
        .hwctl_o  (act_hwctl),
        .mnd_en_o (mnd_en),
        .m_o      (act_m),
        .n_o      (act_n),
        .d2_o     (act_d2)
    );

    always_ff @(posedge clk) begin
        if (rst)
            root_on_q <= 1'b0;
        else
            root_on_q <= root_req | force_on;
    end

    assign root_on = root_on_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CMD: begin
                bus_rdata[CMD_UPD_BIT]            = pend;
                bus_rdata[CMD_FORCE_BIT]          = force_on;
                bus_rdata[CMD_DIRTY_LSB +: 4]     = dirty;
                bus_rdata[CMD_OFF_BIT]            = ~root_on_q;
            end
            ADR_CFG: bus_rdata = cfg_to_word(stg.cfg);
            ADR_M:   bus_rdata[MND_W-1:0] = stg.mnd.m;
            ADR_N:   bus_rdata[MND_W-1:0] = stg.mnd.nreg;
            ADR_D:   bus_rdata[MND_W-1:0] = stg.mnd.dreg;
            default: bus_rdata = '0;
        endcase
    end

    // independent cycle count of the pending window
    logic [LCW-1:0] pend_cyc;
    always_ff @(posedge clk) begin
        if (rst || !pend)
            pend_cyc <= '0;
        else
            pend_cyc <= pend_cyc + LCW'(1);
    end

    // R3
    commit_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> (pend_cyc == LCW'(COMMIT_LAT)));

    // R10
    force_root_chk: assert property (@(posedge clk) disable iff (rst)
        force_on |=> root_on_q);

endmodule

// File: tb/test_clk_root_cfg.sv
module test_clk_root_cfg;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        root_req = 1'b0;
    logic [2:0]  act_src;
    logic [4:0]  act_hdiv;
    logic        act_bypass, act_hwctl, mnd_en, root_on;
    logic [7:0]  act_m, act_n, act_d2;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    clk_root_cfg #(.COMMIT_LAT(LAT)) i_clk_root_cfg (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .root_req(root_req),
        .act_src(act_src), .act_hdiv(act_hdiv), .act_bypass(act_bypass),
        .act_hwctl(act_hwctl), .mnd_en(mnd_en), .act_m(act_m), .act_n(act_n),
        .act_d2(act_d2), .root_on(root_on)
    );

    typedef struct packed {
        logic [2:0] src;
        logic [1:0] mode;
        logic [4:0] hdiv;
        logic [7:0] m;
        logic [7:0] n;
        logic [7:0] d2;
        logic [7:0] exp_d2;
        logic       exp_en;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{3'd3, 2'd2, 5'd3,  8'd1,  8'd4,   8'd4,   8'd3,  1'b1},
        '{3'd5, 2'd2, 5'd0,  8'd5,  8'd5,   8'd5,   8'd0,  1'b0},
        '{3'd1, 2'd0, 5'd9,  8'd3,  8'd20,  8'd10,  8'd10, 1'b0},
        '{3'd7, 2'd2, 5'd31, 8'd2,  8'd200, 8'd1,   8'd2,  1'b1},
        '{3'd2, 2'd2, 5'd6,  8'd10, 8'd100, 8'd150, 8'd90, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [2:0]  prev_src;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h00, r); chk("R1 cmd", r, 32'h8000_0000);
        rd(5'h04, r); chk("R1 cfg", r, 32'h0);
        chk("R1 src/hdiv/m", {act_src, act_hdiv, act_m}, 32'h0);
        chk("R1 n/d2 decode", {act_n, act_d2}, 32'h0000_FFFF);
        chk("R1 flags", {mnd_en, act_bypass, root_on}, 32'b010);

        // R2 field layout and R5 dirty flags
        wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, r); chk("R2 cfg fields", r, 32'h0010_371F);
        wr(5'h08, 32'hFFFF_FFAB); rd(5'h08, r); chk("R2 m", r, 32'h0000_00AB);
        rd(5'h00, r); chk("R5 cfg+m dirty", r, 32'h8000_0050);
        wr(5'h0C, 32'h1234_5678); rd(5'h0C, r); chk("R2 n", r, 32'h0000_0078);
        wr(5'h10, 32'hABCD_EF01); rd(5'h10, r); chk("R2 d", r, 32'h0000_0001);
        rd(5'h00, r); chk("R5 all dirty", r, 32'h8000_00F0);
        chk("R3 no commit yet", {act_src, act_hwctl, act_m}, 32'h0);

        // vector walk: R3 R6 R7 R8 R9 R11
        prev_src = act_src;
        for (int i = 0; i < NV; i++) begin
            wr(5'h04, {18'h0, 1'b0, VEC[i].mode, 1'b0, VEC[i].src, 3'b0, VEC[i].hdiv});
            wr(5'h08, {24'h0, VEC[i].m});
            wr(5'h0C, {24'h0, ~(VEC[i].n - VEC[i].m)});
            wr(5'h10, {24'h0, ~VEC[i].d2});
            wr(5'h00, 32'h1);
            rd(5'h00, r); chk("R3 pending first", {31'h0, r[0]}, 32'h1);
            chk("R3 active held", {29'h0, act_src}, {29'h0, prev_src});
            repeat (LAT - 1) @(negedge clk);
            rd(5'h00, r); chk("R3 pending last", {31'h0, r[0]}, 32'h1);
            chk("R3 active held late", {29'h0, act_src}, {29'h0, prev_src});
            @(negedge clk);
            rd(5'h00, r);
            chk("R11 cmd after commit, root off", r, 32'h8000_0000);
            chk("R3 src", {29'h0, act_src}, {29'h0, VEC[i].src});
            chk("R9 hdiv/bypass", {26'h0, act_hdiv, act_bypass},
                {26'h0, VEC[i].hdiv, VEC[i].hdiv == 5'd0});
            chk("R6 m/n", {16'h0, act_m, act_n}, {16'h0, VEC[i].m, VEC[i].n});
            chk("R7 d2", {24'h0, act_d2}, {24'h0, VEC[i].exp_d2});
            chk("R8 mnd_en", {31'h0, mnd_en}, {31'h0, VEC[i].exp_en});
            prev_src = VEC[i].src;
        end

        // R4 second request while pending
        wr(5'h04, 32'h0000_0400);
        wr(5'h00, 32'h1);
        wr(5'h00, 32'h1);
        repeat (LAT - 3) @(negedge clk);
        rd(5'h00, r); chk("R4 still pending", {31'h0, r[0]}, 32'h1);
        @(negedge clk);
        rd(5'h00, r); chk("R4 done on time", {31'h0, r[0]}, 32'h0);
        chk("R4 src committed", {29'h0, act_src}, 32'h4);
        @(negedge clk);
        rd(5'h00, r); chk("R4 no restart", {31'h0, r[0]}, 32'h0);

        // R10 force-on and root_req
        wr(5'h00, 32'h2);
        chk("R10 not yet on", {31'h0, root_on}, 32'h0);
        @(negedge clk);
        rd(5'h00, r); chk("R10 forced cmd", r, 32'h0000_0002);
        chk("R10 root_on forced", {31'h0, root_on}, 32'h1);
        wr(5'h00, 32'h0);
        @(negedge clk);
        chk("R10 root off again", {31'h0, root_on}, 32'h0);
        root_req = 1'b1;
        @(negedge clk);
        rd(5'h00, r); chk("R10 req cmd", r, 32'h0);
        root_req = 1'b0;
        @(negedge clk);
        rd(5'h00, r); chk("R10 req released", r, 32'h8000_0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule